// File: doc/BRIEF.md
# IQ Quad-Word Formatter

This block gathers receiver output samples and packs them into 16-byte quad-words for a byte-wide link transmitter that sends one quad-word at a time. Its sources are four filter channels, each giving a 16-bit I and a 16-bit Q sample under one shared strobe, and two gain-control loops. Each loop gives an IQ pair and a 12-bit signal-strength value under its own strobe. A three-bit configuration word selects filter-channel data or gain-control data and the order in which entries are laid out. It also selects whether a signal-strength slot follows each gain-control IQ entry. A port-select input chooses which half of a split ordering this instance serves.

An entry is four bytes: the I sample and then the Q sample, each sent most significant byte first. Four entries make one quad-word, and byte 0 (the first byte sent) sits in the top eight bits of the output word. A quad-word is filled half by half, two entries at a time. It is presented on a valid/ready handshake. While a finished word waits, newly arriving samples are kept per source, and only the newest is kept. A change of mode or port throws away a half-built word and any kept samples. The one forbidden configuration raises an error flag and stops all output.

Top module: `iq_quadword_packer`

## Requirements
- R1: With cfg bit 0 clear and cfg bit 1 clear, one channel strobe yields a word whose entries are channel 0, 1, 2, 3 in transmit order. Byte 0 is qw_data[127:120]. Each entry is {I[15:8], I[7:0], Q[15:8], Q[7:0]}. Channel c's sample arrives on ch_iq[32c+31:32c] as {I, Q}. cfg bit 2 has no effect in this mode.
- R2: With cfg bit 0 clear and cfg bit 1 set, two successive channel strobes form a word. The first strobe fills entries 0 and 1. Port A (port_b = 0) carries channels 0,1,0,1 and port B carries channels 2,3,2,3.
- R3: With cfg bits {2,1,0} = 101, the word is loop A, loop B, loop A, loop B. Each half waits until both loops have supplied a sample, in either order or together. Loop n's IQ arrives on agc_iq[32n+31:32n].
- R4: With cfg bits {2,1,0} = 001, the word is A IQ, A strength slot, B IQ, B strength slot. The loop A half always comes first, whatever order the strobes arrive in. A strength slot is the 12-bit value from agc_rssi[12n+11:12n] followed by 20 zero bits.
- R5: With cfg bits {2,1,0} = 011, port A carries only loop A and port B carries only loop B, each as IQ then strength slot, twice per word. Strobes of the other loop have no effect on the word.
- R6: cfg bits {2,1,0} = 111 drives config_error high in the same cycle. A pending word is withdrawn on the next clock edge, and no word is produced while the setting stays. All other settings keep config_error low.
- R7: Once qw_valid is high, qw_valid and qw_data hold steady until qw_ready is sampled high. qw_valid is low in the cycle after that handshake.
- R8: Samples that arrive while a word is pending, or while their turn has not yet come, are kept per source with the newest winning. They fill the next word as soon as the slot is free.
- R9: A change of the decoded mode or of port_b discards a half-built word and all kept samples. A later word is built only from samples that arrive after the change.
- R10: After reset, qw_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg | input | 3 | Format setting (bit 0 source, bit 1 ordering, bit 2 strength-slot omit) |
| port_b | input | 1 | 0 serves port A ordering, 1 serves port B ordering |
| ch_vld | input | 1 | Strobe: all four channel samples present |
| ch_iq | input | 128 | Four channel entries, channel c at [32c+31:32c] as {I, Q} |
| agc_vld | input | 2 | Per-loop sample strobe |
| agc_iq | input | 64 | Two loop IQ entries, loop n at [32n+31:32n] as {I, Q} |
| agc_rssi | input | 24 | Two 12-bit strength values, loop n at [12n+11:12n] |
| qw_ready | input | 1 | Downstream takes the word |
| qw_valid | output | 1 | A full quad-word is on qw_data |
| qw_data | output | 128 | Quad-word, byte 0 in bits 127:120 |
| config_error | output | 1 | Forbidden configuration selected |

## Verification
A wrong half index shows up in the first word after it goes wrong. The two halves come out swapped, or a word completes after one strobe of a split ordering. A stuck or lost kept sample shows up one strobe later, as a word that never becomes valid or one that holds a stale entry in its second half. A missed flush on a mode change shows up as entries from the old mode in the first word under the new one. A missed clear of the valid flag shows up in the very next cycle as qw_valid staying high after a handshake or under the forbidden setting.

// File: rtl/qwp_pkg.sv
package qwp_pkg;

  localparam int N_CH    = 4;
  localparam int N_LOOP  = 2;
  localparam int N_ENTRY = 4;

  typedef enum logic [2:0] {
    MD_CH_SEQ   = 3'd0,
    MD_CH_ALT   = 3'd1,
    MD_AGC_MIX  = 3'd2,
    MD_AGC_RSSI = 3'd3,
    MD_AGC_DED  = 3'd4,
    MD_BAD      = 3'd5
  } qw_mode_e;

  // bit 0: source, bit 1: ordering, bit 2: omit strength slot
  function automatic qw_mode_e decode_cfg(input logic [2:0] c);
    qw_mode_e m;
    if (!c[0]) begin
      m = c[1] ? MD_CH_ALT : MD_CH_SEQ;
    end else begin
      case (c[2:1])
        2'b00:   m = MD_AGC_RSSI;
        2'b10:   m = MD_AGC_MIX;
        2'b01:   m = MD_AGC_DED;
        default: m = MD_BAD;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/qwp_hold.sv
module qwp_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         vld,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         avail,
  output logic [W-1:0] dout
);

  logic         held_q, held_d;
  logic [W-1:0] data_q;
  logic         data_en;

  always_comb begin
    data_en = vld & ~flush & ~take;
    if (flush)      held_d = 1'b0;
    else if (take)  held_d = 1'b0;
    else if (vld)   held_d = 1'b1;
    else            held_d = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      data_q <= '0;
    end else begin
      held_q <= held_d;
      if (data_en) data_q <= din;
    end
  end

  assign avail = held_q | vld;
  assign dout  = vld ? din : data_q;

endmodule

// File: rtl/qwp_seq.sv
module qwp_seq
  import qwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  qw_mode_e          mode,
  input  logic              port_b,
  input  logic              flush,
  input  logic              word_full,
  input  logic              ch_av,
  input  logic [N_LOOP-1:0] loop_av,
  output logic              step,
  output logic              take_ch,
  output logic [N_LOOP-1:0] take_loop,
  output logic              half_q,
  output logic              whole,
  output logic              last
);

  logic              need_ch;
  logic [N_LOOP-1:0] need_loop;
  logic              src_ok;
  logic              half_d;

  always_comb begin
    need_ch   = 1'b0;
    need_loop = '0;
    whole     = 1'b0;
    case (mode)
      MD_CH_SEQ: begin
        need_ch = 1'b1;
        whole   = 1'b1;
      end
      MD_CH_ALT:   need_ch = 1'b1;
      MD_AGC_MIX:  need_loop = '1;
      MD_AGC_RSSI: need_loop = half_q ? 2'b10 : 2'b01;
      MD_AGC_DED:  need_loop = port_b ? 2'b10 : 2'b01;
      default: begin
        need_ch   = 1'b0;
        need_loop = '0;
      end
    endcase

    src_ok    = (!need_ch || ch_av) && ((need_loop & ~loop_av) == '0);
    step      = (mode != MD_BAD) && !flush && !word_full && src_ok &&
                (need_ch || (need_loop != '0));
    take_ch   = step & need_ch;
    take_loop = step ? need_loop : '0;
    last      = whole | half_q;

    if (flush)      half_d = 1'b0;
    else if (step)  half_d = whole ? 1'b0 : ~half_q;
    else            half_d = half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

endmodule

// File: rtl/qwp_asm.sv
module qwp_asm
  import qwp_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int RSSI_W  = 12,
  localparam int LOOP_W = ENTRY_W + RSSI_W,
  localparam int WORD_W = ENTRY_W * N_ENTRY,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  qw_mode_e                 mode,
  input  logic                     port_b,
  input  logic                     half_q,
  input  logic                     step,
  input  logic                     whole,
  input  logic                     last,
  input  logic                     kill,
  input  logic                     qw_ready,
  input  logic [N_CH*ENTRY_W-1:0]  ch_dat,
  input  logic [N_LOOP*LOOP_W-1:0] loop_dat,
  output logic                     qw_valid,
  output logic [WORD_W-1:0]        qw_data
);

  logic [ENTRY_W-1:0] ch_e [N_CH];
  logic [ENTRY_W-1:0] lp_iq [N_LOOP];
  logic [ENTRY_W-1:0] lp_rs [N_LOOP];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch_e[c] = ch_dat[c*ENTRY_W +: ENTRY_W];
  end

  for (genvar n = 0; n < N_LOOP; n++) begin : g_lp
    assign lp_iq[n] = loop_dat[n*LOOP_W + RSSI_W +: ENTRY_W];
    assign lp_rs[n] = {loop_dat[n*LOOP_W +: RSSI_W], {(ENTRY_W-RSSI_W){1'b0}}};
  end

  logic [HALF_W-1:0] half_dat;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              sel;

  always_comb begin
    sel = port_b;
    case (mode)
      MD_CH_ALT:   half_dat = port_b ? {ch_e[2], ch_e[3]} : {ch_e[0], ch_e[1]};
      MD_AGC_MIX:  half_dat = {lp_iq[0], lp_iq[1]};
      MD_AGC_RSSI: half_dat = half_q ? {lp_iq[1], lp_rs[1]} : {lp_iq[0], lp_rs[0]};
      MD_AGC_DED:  half_dat = {lp_iq[sel], lp_rs[sel]};
      default:     half_dat = {ch_e[0], ch_e[1]};
    endcase

    word_d = word_q;
    if (whole)        word_d = {ch_e[0], ch_e[1], ch_e[2], ch_e[3]};
    else if (!half_q) word_d[WORD_W-1 -: HALF_W] = half_dat;
    else              word_d[HALF_W-1:0] = half_dat;

    if (kill)                    valid_d = 1'b0;
    else if (valid_q && qw_ready) valid_d = 1'b0;
    else if (step && last)       valid_d = 1'b1;
    else                         valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (step) word_q <= word_d;
    end
  end

  assign qw_valid = valid_q;
  assign qw_data  = word_q;

endmodule

// File: rtl/iq_quadword_packer.sv
module iq_quadword_packer
  import qwp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RSSI_W   = 12,
  localparam int ENTRY_W = 2 * SAMPLE_W,
  localparam int LOOP_W  = ENTRY_W + RSSI_W,
  localparam int WORD_W  = ENTRY_W * N_ENTRY
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cfg,
  input  logic                     port_b,
  input  logic                     ch_vld,
  input  logic [N_CH*ENTRY_W-1:0]  ch_iq,
  input  logic [N_LOOP-1:0]        agc_vld,
  input  logic [N_LOOP*ENTRY_W-1:0] agc_iq,
  input  logic [N_LOOP*RSSI_W-1:0] agc_rssi,
  input  logic                     qw_ready,
  output logic                     qw_valid,
  output logic [WORD_W-1:0]        qw_data,
  output logic                     config_error
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // configuration decode and change detection
  qw_mode_e mode, mode_q;
  logic     port_q;
  logic     cfg_bad, flush;

  always_comb begin
    mode    = decode_cfg(cfg);
    cfg_bad = (mode == MD_BAD);
    flush   = cfg_bad | (mode != mode_q) | (port_b != port_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= MD_CH_SEQ;
      port_q <= 1'b0;
    end else begin
      mode_q <= mode;
      port_q <= port_b;
    end
  end

  assign config_error = cfg_bad;

  // per-source sample holders
  logic                     ch_av, seq_take_ch;
  logic [N_CH*ENTRY_W-1:0]  ch_dat;
  logic [N_LOOP-1:0]        loop_av, seq_take_loop;
  logic [N_LOOP*LOOP_W-1:0] loop_dat;

  qwp_hold #(.W(N_CH*ENTRY_W)) i_ch_hold (
    .clk   (clk),
    .rst_n (srst_n),
    .flush (flush),
    .vld   (ch_vld),
    .din   (ch_iq),
    .take  (seq_take_ch),
    .avail (ch_av),
    .dout  (ch_dat)
  );

  for (genvar n = 0; n < N_LOOP; n++) begin : g_loop
    qwp_hold #(.W(LOOP_W)) i_loop_hold (
      .clk   (clk),
      .rst_n (srst_n),
      .flush (flush),
      .vld   (agc_vld[n]),
      .din   ({agc_iq[n*ENTRY_W +: ENTRY_W], agc_rssi[n*RSSI_W +: RSSI_W]}),
      .take  (seq_take_loop[n]),
      .avail (loop_av[n]),
      .dout  (loop_dat[n*LOOP_W +: LOOP_W])
    );
  end

  // fill sequencing
  logic seq_step, seq_half, seq_whole, seq_last;

  qwp_seq i_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .mode      (mode),
    .port_b    (port_b),
    .flush     (flush),
    .word_full (qw_valid),
    .ch_av     (ch_av),
    .loop_av   (loop_av),
    .step      (seq_step),
    .take_ch   (seq_take_ch),
    .take_loop (seq_take_loop),
    .half_q    (seq_half),
    .whole     (seq_whole),
    .last      (seq_last)
  );

  // word assembly and output register
  qwp_asm #(.ENTRY_W(ENTRY_W), .RSSI_W(RSSI_W)) i_asm (
    .clk      (clk),
    .rst_n    (srst_n),
    .mode     (mode),
    .port_b   (port_b),
    .half_q   (seq_half),
    .step     (seq_step),
    .whole    (seq_whole),
    .last     (seq_last),
    .kill     (cfg_bad),
    .qw_ready (qw_ready),
    .ch_dat   (ch_dat),
    .loop_dat (loop_dat),
    .qw_valid (qw_valid),
    .qw_data  (qw_data)
  );

endmodule

// File: rtl/qwp_checker.sv
module qwp_checker #(
  parameter int WORD_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              qw_valid,
  input logic              qw_ready,
  input logic [WORD_W-1:0] qw_data,
  input logic              config_error,
  input logic              seq_step
);

  AST_PENDING_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid && !qw_ready && !config_error |=> qw_valid && $stable(qw_data)); // R7

  AST_GAP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid && qw_ready |=> !qw_valid); // R7

  AST_BAD_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> !qw_valid); // R6

  AST_FILL_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_step |-> !qw_valid); // R8

  AST_VALID_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qw_valid) |-> $past(seq_step)); // R1

endmodule

bind iq_quadword_packer qwp_checker #(.WORD_W(WORD_W)) i_qwp_checker (
  .clk          (clk),
  .rst_n        (srst_n),
  .qw_valid     (qw_valid),
  .qw_ready     (qw_ready),
  .qw_data      (qw_data),
  .config_error (config_error),
  .seq_step     (seq_step)
);

// File: tb/test_iq_quadword_packer.sv
`timescale 1ns/1ps
module test_iq_quadword_packer;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   cfg;
  logic         port_b;
  logic         ch_vld;
  logic [127:0] ch_iq;
  logic [1:0]   agc_vld;
  logic [63:0]  agc_iq;
  logic [23:0]  agc_rssi;
  logic         qw_ready;
  logic         qw_valid;
  logic [127:0] qw_data;
  logic         config_error;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  iq_quadword_packer i_iq_quadword_packer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg          (cfg),
    .port_b       (port_b),
    .ch_vld       (ch_vld),
    .ch_iq        (ch_iq),
    .agc_vld      (agc_vld),
    .agc_iq       (agc_iq),
    .agc_rssi     (agc_rssi),
    .qw_ready     (qw_ready),
    .qw_valid     (qw_valid),
    .qw_data      (qw_data),
    .config_error (config_error)
  );

  function automatic logic [31:0] ch_of(input logic [127:0] d, input int c);
    return d[c*32 +: 32];
  endfunction

  function automatic logic [31:0] slot(input logic [11:0] r);
    return {r, 20'h0};
  endfunction

  function automatic logic [127:0] seq_word(input logic [127:0] d);
    return {ch_of(d, 0), ch_of(d, 1), ch_of(d, 2), ch_of(d, 3)};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // samples of the most recent strobes
  logic [127:0] last_ch;
  logic [31:0]  last_iq [2];
  logic [11:0]  last_rs [2];

  task automatic strobe(input bit do_ch, input logic [1:0] lp);
    if (do_ch) begin
      last_ch = {$urandom, $urandom, $urandom, $urandom};
      ch_iq   = last_ch;
      ch_vld  = 1'b1;
    end
    for (int n = 0; n < 2; n++) begin
      if (lp[n]) begin
        last_iq[n] = $urandom;
        last_rs[n] = 12'($urandom);
        agc_iq[n*32 +: 32]   = last_iq[n];
        agc_rssi[n*12 +: 12] = last_rs[n];
      end
    end
    agc_vld = lp;
    @(negedge clk);
    ch_vld  = 1'b0;
    agc_vld = 2'b00;
  endtask

  task automatic take_word();
    qw_ready = 1'b1;
    @(negedge clk);
    qw_ready = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] c, input logic p);
    cfg    = c;
    port_b = p;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] w1, w2, w3;
    logic [31:0]  a1, b1, b2;
    logic [11:0]  ra1, rb2;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cfg = 3'b000; port_b = 1'b0; ch_vld = 1'b0; ch_iq = '0;
    agc_vld = 2'b00; agc_iq = '0; agc_rssi = '0; qw_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10", {127'b0, qw_valid}, 128'd0);
    check("R6 flag low", {127'b0, config_error}, 128'd0);

    // R1 sequential channels, bit 2 ignored
    for (int k = 0; k < 2; k++) begin
      set_cfg(k ? 3'b100 : 3'b000, 1'b0);
      strobe(1'b1, 2'b00);
      check("R1 valid", {127'b0, qw_valid}, 128'd1);
      check("R1 data", qw_data, seq_word(last_ch));
      take_word();
      check("R7 gap", {127'b0, qw_valid}, 128'd0);
    end

    // R2 alternating pairs, both ports
    for (int p = 0; p < 2; p++) begin
      set_cfg(3'b010, p[0]);
      strobe(1'b1, 2'b00); w1 = last_ch;
      check("R2 half only", {127'b0, qw_valid}, 128'd0);
      strobe(1'b1, 2'b00); w2 = last_ch;
      check("R2 data", qw_data, p ? {ch_of(w1,2), ch_of(w1,3), ch_of(w2,2), ch_of(w2,3)}
                                  : {ch_of(w1,0), ch_of(w1,1), ch_of(w2,0), ch_of(w2,1)});
      take_word();
    end

    // R3 interleaved loops: B first, then A, then both together
    set_cfg(3'b101, 1'b0);
    strobe(1'b0, 2'b10); b1 = last_iq[1];
    check("R3 wait A", {127'b0, qw_valid}, 128'd0);
    strobe(1'b0, 2'b01); a1 = last_iq[0];
    strobe(1'b0, 2'b11);
    check("R3 data", qw_data, {a1, b1, last_iq[0], last_iq[1]});
    take_word();

    // R4 strength slots, B arrives twice before A (R8 newest wins)
    set_cfg(3'b001, 1'b0);
    strobe(1'b0, 2'b10);
    strobe(1'b0, 2'b10); b2 = last_iq[1]; rb2 = last_rs[1];
    check("R4 wait A", {127'b0, qw_valid}, 128'd0);
    strobe(1'b0, 2'b01); a1 = last_iq[0]; ra1 = last_rs[0];
    @(negedge clk);
    check("R4 R8 data", qw_data, {a1, slot(ra1), b2, slot(rb2)});
    take_word();

    // R5 dedicated loop per port, other loop strobes ignored
    for (int p = 0; p < 2; p++) begin
      set_cfg(3'b011, p[0]);
      strobe(1'b0, 2'b11); a1 = last_iq[p]; ra1 = last_rs[p];
      strobe(1'b0, p ? 2'b01 : 2'b10);
      check("R5 other ignored", {127'b0, qw_valid}, 128'd0);
      strobe(1'b0, 2'b11);
      check("R5 data", qw_data, {a1, slot(ra1), last_iq[p], slot(last_rs[p])});
      take_word();
    end

    // R6 forbidden setting withdraws a pending word and blocks output
    set_cfg(3'b011, 1'b0);
    strobe(1'b0, 2'b01);
    strobe(1'b0, 2'b01);
    check("R6 pending", {127'b0, qw_valid}, 128'd1);
    cfg = 3'b111;
    #1;
    check("R6 flag", {127'b0, config_error}, 128'd1);
    @(negedge clk);
    check("R6 withdrawn", {127'b0, qw_valid}, 128'd0);
    strobe(1'b1, 2'b11);
    strobe(1'b0, 2'b11);
    repeat (2) @(negedge clk);
    check("R6 quiet", {127'b0, qw_valid}, 128'd0);

    // R7 R8 backpressure with samples arriving during the wait
    set_cfg(3'b000, 1'b0);
    strobe(1'b1, 2'b00); w1 = last_ch;
    repeat (3) @(negedge clk);
    strobe(1'b1, 2'b00);
    strobe(1'b1, 2'b00); w3 = last_ch;
    check("R7 steady", qw_data, seq_word(w1));
    take_word();
    check("R7 gap", {127'b0, qw_valid}, 128'd0);
    @(negedge clk);
    check("R8 held used", qw_data, seq_word(w3));
    take_word();

    // R9 port change discards half-built word
    set_cfg(3'b010, 1'b0);
    strobe(1'b1, 2'b00);
    set_cfg(3'b010, 1'b1);
    strobe(1'b1, 2'b00); w1 = last_ch;
    check("R9 restart", {127'b0, qw_valid}, 128'd0);
    strobe(1'b1, 2'b00); w2 = last_ch;
    check("R9 data", qw_data, {ch_of(w1,2), ch_of(w1,3), ch_of(w2,2), ch_of(w2,3)});
    take_word();

    // R9 mode change discards a kept loop sample
    set_cfg(3'b001, 1'b0);
    strobe(1'b0, 2'b10);
    set_cfg(3'b101, 1'b0);
    strobe(1'b0, 2'b01);
    repeat (2) @(negedge clk);
    check("R9 kept dropped", {127'b0, qw_valid}, 128'd0);
    set_cfg(3'b000, 1'b0);

    // random mix of legal settings
    for (int it = 0; it < 40; it++) begin
      int md;
      logic p;
      logic [127:0] exp;
      md = int'($urandom_range(0, 4));
      p  = 1'($urandom);
      case (md)
        0: begin
          set_cfg(3'b000, p);
          strobe(1'b1, 2'b00);
          exp = seq_word(last_ch);
        end
        1: begin
          set_cfg(3'b110, p);
          strobe(1'b1, 2'b00); w1 = last_ch;
          strobe(1'b1, 2'b00); w2 = last_ch;
          exp = p ? {ch_of(w1,2), ch_of(w1,3), ch_of(w2,2), ch_of(w2,3)}
                  : {ch_of(w1,0), ch_of(w1,1), ch_of(w2,0), ch_of(w2,1)};
        end
        2: begin
          set_cfg(3'b101, p);
          strobe(1'b0, 2'b11); a1 = last_iq[0]; b1 = last_iq[1];
          strobe(1'b0, 2'b11);
          exp = {a1, b1, last_iq[0], last_iq[1]};
        end
        3: begin
          set_cfg(3'b001, p);
          strobe(1'b0, 2'b11);
          exp = {last_iq[0], slot(last_rs[0]), last_iq[1], slot(last_rs[1])};
        end
        default: begin
          set_cfg(3'b011, p);
          strobe(1'b0, 2'b11); a1 = last_iq[p]; ra1 = last_rs[p];
          strobe(1'b0, 2'b11);
          exp = {a1, slot(ra1), last_iq[p], slot(last_rs[p])};
        end
      endcase
      repeat (2) @(negedge clk);
      case (md)
        0:       check("R1 rand", qw_data, exp);
        1:       check("R2 rand", qw_data, exp);
        2:       check("R3 rand", qw_data, exp);
        3:       check("R4 rand", qw_data, exp);
        default: check("R5 rand", qw_data, exp);
      endcase
      check("R7 rand valid", {127'b0, qw_valid}, 128'd1);
      take_word();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule